// File: doc/BRIEF.md
# SPI DMA Request Handshake with Switchable FIFOs

This block sits between an SPI peripheral's data path and a DMA controller. It keeps a transmit queue and a receive queue, each either one entry deep or a small FIFO. From their occupancy it derives two status flags: transmit has room, and receive data is waiting. It turns those flags into registered request lines for the DMA controller. When the controller finishes a transfer it sends a done pulse, and the pulse clears the matching flag. With the FIFOs on, one request can be answered by a burst of several bytes, or of several 16-bit words.

The data mode sets the width of each entry, 8 bits or 16 bits. Together with the FIFO switch it also sets how many entries a queue may hold. A plain loopback model stands in for the serial shifter: on each shift tick it moves the oldest transmit entry into the receive queue. This lets the receive side be exercised without a real serial line. Software changes the FIFO switch and the data mode only while the SPI enable is low.

Top module: `spi_dma_link`

## Requirements
- R1: After reset tx_req and rx_req are 0, tx_empty is 1, rx_full is 0, tx_overflow is 0, and both counts are 0.
- R2: tx_req after a clock edge equals tx_dma_en AND spi_en (sampled at that edge) AND the tx_empty value produced at that same edge.
- R3: rx_req after a clock edge equals rx_dma_en AND spi_en (sampled at that edge) AND the rx_full value produced at that same edge.
- R4: Queue capacity is 1 entry when fifo_mode=0. It is FIFO_BYTES entries when fifo_mode=1 and wide_mode=0 (8-bit data). It is FIFO_BYTES/2 entries when fifo_mode=1 and wide_mode=1 (16-bit data). tx_count never exceeds this capacity while spi_en is 1.
- R5: tx_empty is cleared only by a tx_done pulse in a cycle that leaves the transmit queue at capacity. A tx_done pulse that leaves free space does not clear it, and writes without tx_done do not clear it.
- R6: tx_empty is set again in every cycle in which the shifter removes a transmit entry.
- R7: rx_full is set in every cycle in which a receive entry arrives. It is cleared only by an rx_done pulse in a cycle that leaves the receive queue empty.
- R8: A write to a full transmit queue is dropped and sets tx_overflow, which stays set until spi_en goes low.
- R9: While spi_en is 0, both queues are emptied, tx_empty is forced to 1, rx_full, tx_overflow, tx_req and rx_req are forced to 0, and writes and reads have no effect.
- R10: With wide_mode=0 only bits 7:0 of wr_data are kept and rd_data[15:8] is zero. With wide_mode=1 all 16 bits are kept. Both queues are first in, first out.
- R11: In a cycle with shift_tick=1 and spi_en=1, if the transmit queue is not empty and the receive queue is below capacity, the oldest transmit entry moves to the tail of the receive queue.
- R12: rd_data shows the oldest receive entry, or zero when the receive queue is empty. rd_strobe removes that entry, and rd_strobe on an empty queue changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_en | input | 1 | SPI enable; low flushes the block |
| fifo_mode | input | 1 | 1 selects multi-entry queues |
| wide_mode | input | 1 | 1 selects 16-bit entries, 0 selects 8-bit |
| tx_dma_en | input | 1 | Transmit DMA enable |
| rx_dma_en | input | 1 | Receive DMA enable |
| wr_valid | input | 1 | Data register write strobe |
| wr_data | input | 16 | Write data |
| tx_done | input | 1 | Transmit DMA done pulse |
| rd_strobe | input | 1 | Data register read strobe |
| rd_data | output | 16 | Oldest receive entry |
| rx_done | input | 1 | Receive DMA done pulse |
| shift_tick | input | 1 | Loopback shifter advance |
| tx_req | output | 1 | Transmit DMA request |
| rx_req | output | 1 | Receive DMA request |
| tx_empty | output | 1 | Transmit queue has room flag |
| rx_full | output | 1 | Receive data waiting flag |
| tx_overflow | output | 1 | Sticky dropped-write flag |
| tx_count | output | 4 | Transmit queue occupancy |
| rx_count | output | 4 | Receive queue occupancy |

## Verification
The hardest state to reach is a tx_done pulse that arrives in exactly the cycle the transmit queue reaches capacity, with no shift tick in the same cycle. Only this combination clears tx_empty. Random traffic rarely produces it in the 8-entry byte mode. Directed sequences therefore fill the queue to one short of capacity and attach the done pulse to the filling write, once for each mode. A further write then hits the overflow path. Long randomized runs in each of the three capacity modes, with occasional drops of spi_en, are compared every cycle against a queue model kept in the bench.

// File: rtl/spi_dma_pkg.sv
package spi_dma_pkg;

  typedef enum logic [1:0] {
    DEPTH_ONE   = 2'd0,
    DEPTH_BYTES = 2'd1,
    DEPTH_WORDS = 2'd2
  } depth_sel_e;

  function automatic depth_sel_e depth_sel(input logic fifo_on, input logic wide);
    if (!fifo_on)  return DEPTH_ONE;
    else if (wide) return DEPTH_WORDS;
    else           return DEPTH_BYTES;
  endfunction

  function automatic int unsigned depth_of(input depth_sel_e sel, input int unsigned bytes);
    case (sel)
      DEPTH_BYTES: return bytes;
      DEPTH_WORDS: return bytes / 2;
      default:     return 1;
    endcase
  endfunction

endpackage

// File: rtl/spi_dma_fifo.sv
module spi_dma_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic [CW-1:0] cap,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          push_ok,
  output logic          pop_ok,
  output logic          full,
  output logic          empty
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr_q, wptr_n;
  logic [AW-1:0] rptr_q, rptr_n;
  logic [CW-1:0] cnt_q, cnt_n;

  assign full    = (cnt_q >= cap);
  assign empty   = (cnt_q == '0);
  assign push_ok = push && !full && !flush;
  assign pop_ok  = pop && !empty && !flush;
  assign dout    = mem[rptr_q];
  assign count   = cnt_q;

  always_comb begin
    wptr_n = wptr_q;
    rptr_n = rptr_q;
    cnt_n  = cnt_q;
    if (flush) begin
      wptr_n = '0;
      rptr_n = '0;
      cnt_n  = '0;
    end else begin
      if (push_ok) wptr_n = wptr_q + AW'(1);
      if (pop_ok)  rptr_n = rptr_q + AW'(1);
      cnt_n = cnt_q + CW'(push_ok) - CW'(pop_ok);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_n;
      rptr_q <= rptr_n;
      cnt_q  <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr_q] <= din;
  end

endmodule

// File: rtl/spi_dma_txstat.sv
module spi_dma_txstat #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          spi_en,
  input  logic          dma_en,
  input  logic          done,
  input  logic          wr_try,
  input  logic          push_ok,
  input  logic          pop_ok,
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] cap,
  output logic          room_flag,
  output logic          req,
  output logic          overflow
);

  logic          room_q, room_n;
  logic          req_q, req_n;
  logic          ovf_q, ovf_n;
  logic [CW-1:0] cnt_after;

  assign cnt_after = count + CW'(push_ok) - CW'(pop_ok);

  always_comb begin
    room_n = room_q;
    ovf_n  = ovf_q;
    if (!spi_en) begin
      room_n = 1'b1;
      ovf_n  = 1'b0;
    end else begin
      if (pop_ok)                           room_n = 1'b1;
      else if (done && (cnt_after == cap))  room_n = 1'b0;
      if (wr_try && !push_ok)               ovf_n  = 1'b1;
    end
    req_n = dma_en && spi_en && room_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      room_q <= 1'b1;
      req_q  <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      room_q <= room_n;
      req_q  <= req_n;
      ovf_q  <= ovf_n;
    end
  end

  assign room_flag = room_q;
  assign req       = req_q;
  assign overflow  = ovf_q;

endmodule

// File: rtl/spi_dma_rxstat.sv
module spi_dma_rxstat #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          spi_en,
  input  logic          dma_en,
  input  logic          done,
  input  logic          push_ok,
  input  logic          pop_ok,
  input  logic [CW-1:0] count,
  output logic          data_flag,
  output logic          req
);

  logic          data_q, data_n;
  logic          req_q, req_n;
  logic [CW-1:0] cnt_after;

  assign cnt_after = count + CW'(push_ok) - CW'(pop_ok);

  always_comb begin
    data_n = data_q;
    if (!spi_en)                           data_n = 1'b0;
    else if (push_ok)                      data_n = 1'b1;
    else if (done && (cnt_after == '0))    data_n = 1'b0;
    req_n = dma_en && spi_en && data_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      data_q <= data_n;
      req_q  <= req_n;
    end
  end

  assign data_flag = data_q;
  assign req       = req_q;

endmodule

// File: rtl/spi_dma_loopback.sv
module spi_dma_loopback #(
  parameter int W = 16
) (
  input  logic         spi_en,
  input  logic         tick,
  input  logic         src_empty,
  input  logic         dst_full,
  input  logic [W-1:0] src_data,
  output logic         move,
  output logic [W-1:0] dst_data
);

  assign move     = spi_en && tick && !src_empty && !dst_full;
  assign dst_data = src_data;

endmodule

// File: rtl/spi_dma_link.sv
module spi_dma_link
  import spi_dma_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int FIFO_BYTES = 8,
  localparam int DATA_W    = 2 * BYTE_W,
  localparam int CNT_W     = $clog2(FIFO_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_en,
  input  logic              fifo_mode,
  input  logic              wide_mode,
  input  logic              tx_dma_en,
  input  logic              rx_dma_en,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tx_done,
  input  logic              rd_strobe,
  output logic [DATA_W-1:0] rd_data,
  input  logic              rx_done,
  input  logic              shift_tick,
  output logic              tx_req,
  output logic              rx_req,
  output logic              tx_empty,
  output logic              rx_full,
  output logic              tx_overflow,
  output logic [CNT_W-1:0]  tx_count,
  output logic [CNT_W-1:0]  rx_count
);

  depth_sel_e        sel;
  logic [CNT_W-1:0]  cap;
  logic              flush;
  logic [DATA_W-1:0] wr_masked;

  logic              tx_push_ok, tx_pop_ok, tx_full_q, tx_empty_q;
  logic [DATA_W-1:0] tx_head;
  logic              rx_push_ok, rx_pop_ok, rx_full_q, rx_empty_q;
  logic [DATA_W-1:0] rx_head, rx_in;
  logic              move;

  assign sel   = depth_sel(fifo_mode, wide_mode);
  assign cap   = CNT_W'(depth_of(sel, FIFO_BYTES));
  assign flush = !spi_en;

  generate
    if (BYTE_W < DATA_W) begin : g_mask
      assign wr_masked = wide_mode ? wr_data : {{(DATA_W-BYTE_W){1'b0}}, wr_data[BYTE_W-1:0]};
    end else begin : g_nomask
      assign wr_masked = wr_data;
    end
  endgenerate

  spi_dma_fifo #(.W(DATA_W), .DEPTH(FIFO_BYTES)) u_txq (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (flush),
    .cap     (cap),
    .push    (wr_valid),
    .din     (wr_masked),
    .pop     (move),
    .dout    (tx_head),
    .count   (tx_count),
    .push_ok (tx_push_ok),
    .pop_ok  (tx_pop_ok),
    .full    (tx_full_q),
    .empty   (tx_empty_q)
  );

  spi_dma_loopback #(.W(DATA_W)) u_loop (
    .spi_en   (spi_en),
    .tick     (shift_tick),
    .src_empty(tx_empty_q),
    .dst_full (rx_full_q),
    .src_data (tx_head),
    .move     (move),
    .dst_data (rx_in)
  );

  spi_dma_fifo #(.W(DATA_W), .DEPTH(FIFO_BYTES)) u_rxq (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (flush),
    .cap     (cap),
    .push    (move),
    .din     (rx_in),
    .pop     (rd_strobe),
    .dout    (rx_head),
    .count   (rx_count),
    .push_ok (rx_push_ok),
    .pop_ok  (rx_pop_ok),
    .full    (rx_full_q),
    .empty   (rx_empty_q)
  );

  assign rd_data = rx_empty_q ? '0 : rx_head;

  spi_dma_txstat #(.CW(CNT_W)) u_txstat (
    .clk      (clk),
    .rst_n    (rst_n),
    .spi_en   (spi_en),
    .dma_en   (tx_dma_en),
    .done     (tx_done),
    .wr_try   (wr_valid && spi_en),
    .push_ok  (tx_push_ok),
    .pop_ok   (tx_pop_ok),
    .count    (tx_count),
    .cap      (cap),
    .room_flag(tx_empty),
    .req      (tx_req),
    .overflow (tx_overflow)
  );

  spi_dma_rxstat #(.CW(CNT_W)) u_rxstat (
    .clk      (clk),
    .rst_n    (rst_n),
    .spi_en   (spi_en),
    .dma_en   (rx_dma_en),
    .done     (rx_done),
    .push_ok  (rx_push_ok),
    .pop_ok   (rx_pop_ok),
    .count    (rx_count),
    .data_flag(rx_full),
    .req      (rx_req)
  );

endmodule

// File: rtl/spi_dma_link_chk.sv
module spi_dma_link_chk #(
  parameter int BYTE_W     = 8,
  parameter int FIFO_BYTES = 8,
  localparam int DATA_W    = 2 * BYTE_W,
  localparam int CNT_W     = $clog2(FIFO_BYTES + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              spi_en,
  input logic              fifo_mode,
  input logic              wide_mode,
  input logic              tx_dma_en,
  input logic              rx_dma_en,
  input logic              tx_req,
  input logic              rx_req,
  input logic              tx_empty,
  input logic              rx_full,
  input logic              tx_overflow,
  input logic [CNT_W-1:0]  tx_count,
  input logic [CNT_W-1:0]  rx_count
);

  logic [CNT_W-1:0] lim;
  assign lim = !fifo_mode ? CNT_W'(1) : (wide_mode ? CNT_W'(FIFO_BYTES / 2) : CNT_W'(FIFO_BYTES));

  assert_txreq_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |-> (tx_empty && $past(tx_dma_en && spi_en)));

  assert_rxreq_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_req |-> (rx_full && $past(rx_dma_en && spi_en)));

  assert_tx_within_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    spi_en |-> (tx_count <= lim && rx_count <= lim));

  assert_txflag_clear_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_en && !tx_empty) |-> (tx_count == lim));

  assert_rxdata_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_en && rx_count != '0) |-> rx_full);

  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_overflow && spi_en) |=> tx_overflow);

  assert_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_en |=> (tx_count == '0 && rx_count == '0 && tx_empty && !rx_full
                 && !tx_overflow && !tx_req && !rx_req));

endmodule

bind spi_dma_link spi_dma_link_chk #(.BYTE_W(BYTE_W), .FIFO_BYTES(FIFO_BYTES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .spi_en     (spi_en),
  .fifo_mode  (fifo_mode),
  .wide_mode  (wide_mode),
  .tx_dma_en  (tx_dma_en),
  .rx_dma_en  (rx_dma_en),
  .tx_req     (tx_req),
  .rx_req     (rx_req),
  .tx_empty   (tx_empty),
  .rx_full    (rx_full),
  .tx_overflow(tx_overflow),
  .tx_count   (tx_count),
  .rx_count   (rx_count)
);

// File: tb/test_spi_dma_link.sv
module test_spi_dma_link;

  localparam int CLK_PERIOD = 10;
  localparam int NBYTES     = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        spi_en, fifo_mode, wide_mode, tx_dma_en, rx_dma_en;
  logic        wr_valid, tx_done, rd_strobe, rx_done, shift_tick;
  logic [15:0] wr_data;
  logic [15:0] rd_data;
  logic        tx_req, rx_req, tx_empty, rx_full, tx_overflow;
  logic [3:0]  tx_count, rx_count;

  int checks = 0;
  int errors = 0;

  logic [15:0] txq[$];
  logic [15:0] rxq[$];
  logic m_tef, m_rff, m_ovf, m_txreq, m_rxreq;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_dma_link i_spi_dma_link (
    .clk(clk), .rst_n(rst_n), .spi_en(spi_en), .fifo_mode(fifo_mode),
    .wide_mode(wide_mode), .tx_dma_en(tx_dma_en), .rx_dma_en(rx_dma_en),
    .wr_valid(wr_valid), .wr_data(wr_data), .tx_done(tx_done),
    .rd_strobe(rd_strobe), .rd_data(rd_data), .rx_done(rx_done),
    .shift_tick(shift_tick), .tx_req(tx_req), .rx_req(rx_req),
    .tx_empty(tx_empty), .rx_full(rx_full), .tx_overflow(tx_overflow),
    .tx_count(tx_count), .rx_count(rx_count)
  );

  function automatic int cap_now();
    if (!fifo_mode) return 1;
    return wide_mode ? NBYTES / 2 : NBYTES;
  endfunction

  function automatic logic [15:0] keep(input logic [15:0] v);
    return wide_mode ? v : {8'h00, v[7:0]};
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_update();
    int  cap;
    bit  wr_ok, xfer, rd_ok;
    logic [15:0] v;
    cap = cap_now();
    if (!spi_en) begin
      txq.delete(); rxq.delete();
      m_tef = 1'b1; m_rff = 1'b0; m_ovf = 1'b0;
    end else begin
      xfer  = shift_tick && txq.size() > 0 && rxq.size() < cap;
      wr_ok = wr_valid && txq.size() < cap;
      rd_ok = rd_strobe && rxq.size() > 0;
      v = 16'h0;
      if (xfer) v = txq.pop_front();
      if (wr_ok) txq.push_back(keep(wr_data));
      if (rd_ok) void'(rxq.pop_front());
      if (xfer) rxq.push_back(v);
      if (wr_valid && !wr_ok) m_ovf = 1'b1;
      if (xfer) m_tef = 1'b1;
      else if (tx_done && txq.size() == cap) m_tef = 1'b0;
      if (xfer) m_rff = 1'b1;
      else if (rx_done && rxq.size() == 0) m_rff = 1'b0;
    end
    m_txreq = tx_dma_en && spi_en && m_tef;
    m_rxreq = rx_dma_en && spi_en && m_rff;
  endtask

  task automatic compare_all();
    chk("R2 tx_req",      tx_req,      m_txreq);
    chk("R3 rx_req",      rx_req,      m_rxreq);
    chk("R5 tx_empty",    tx_empty,    m_tef);
    chk("R7 rx_full",     rx_full,     m_rff);
    chk("R8 tx_overflow", tx_overflow, m_ovf);
    chk("R4 tx_count",    tx_count,    txq.size());
    chk("R11 rx_count",   rx_count,    rxq.size());
    chk("R12 rd_data",    rd_data,     rxq.size() > 0 ? rxq[0] : 16'h0);
  endtask

  task automatic cyc();
    model_update();
    @(posedge clk);
    #1;
    compare_all();
    wr_valid = 0; tx_done = 0; rd_strobe = 0; rx_done = 0; shift_tick = 0;
  endtask

  task automatic set_mode(input logic f, input logic w);
    spi_en = 0; fifo_mode = f; wide_mode = w;
    cyc();
    spi_en = 1;
    cyc();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; spi_en = 0; fifo_mode = 0; wide_mode = 0;
    tx_dma_en = 0; rx_dma_en = 0; wr_valid = 0; wr_data = 0;
    tx_done = 0; rd_strobe = 0; rx_done = 0; shift_tick = 0;
    m_tef = 1; m_rff = 0; m_ovf = 0; m_txreq = 0; m_rxreq = 0;
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/2) rst_n = 1;
    #1;
    // R1 reset state
    chk("R1 tx_req", tx_req, 0);
    chk("R1 rx_req", rx_req, 0);
    chk("R1 tx_empty", tx_empty, 1);
    chk("R1 rx_full", rx_full, 0);
    chk("R1 tx_overflow", tx_overflow, 0);
    chk("R1 counts", {tx_count, rx_count}, 0);

    // Byte FIFO burst
    tx_dma_en = 1; rx_dma_en = 1;
    set_mode(1, 0);
    chk("R2 request with room", tx_req, 1);
    for (int i = 0; i < NBYTES - 1; i++) begin
      wr_valid = 1; wr_data = 16'hA531 + 16'(i); cyc();
    end
    chk("R5 writes without done keep flag", tx_empty, 1);
    wr_valid = 1; wr_data = 16'hA538; tx_done = 1; cyc();
    chk("R5 done at capacity clears flag", tx_empty, 0);
    chk("R2 request drops", tx_req, 0);
    chk("R4 byte capacity", tx_count, NBYTES);
    wr_valid = 1; wr_data = 16'h1111; cyc();
    chk("R8 overflow on full write", tx_overflow, 1);
    shift_tick = 1; cyc();
    chk("R6 shift frees room", tx_empty, 1);
    chk("R7 arrival sets rx_full", rx_full, 1);
    chk("R3 rx request", rx_req, 1);
    chk("R10 byte mask", rd_data, 16'h0031);
    rd_strobe = 1; cyc();
    chk("R7 read without done keeps flag", rx_full, 1);
    rx_done = 1; cyc();
    chk("R7 done when empty clears", rx_full, 0);
    rd_strobe = 1; cyc();
    chk("R12 empty read no effect", rx_count, 0);
    chk("R12 empty reads zero", rd_data, 0);
    shift_tick = 1; tx_done = 1; cyc();
    chk("R5 done with free space keeps flag", tx_empty, 1);

    // R9 flush
    spi_en = 0; wr_valid = 1; wr_data = 16'h2222; cyc();
    chk("R9 flush tx", tx_count, 0);
    chk("R9 flush overflow", tx_overflow, 0);
    chk("R9 no request", {tx_req, rx_req}, 0);

    // Word FIFO burst
    set_mode(1, 1);
    for (int i = 0; i < NBYTES / 2; i++) begin
      wr_valid = 1; wr_data = 16'hBEEF + 16'(i); tx_done = (i == NBYTES/2 - 1); cyc();
    end
    chk("R4 word capacity", tx_count, NBYTES / 2);
    chk("R5 word burst clears", tx_empty, 0);
    wr_valid = 1; wr_data = 16'h3333; cyc();
    chk("R8 word overflow", tx_overflow, 1);
    shift_tick = 1; cyc();
    chk("R11 wide loopback data", rd_data, 16'hBEEF);
    chk("R10 fifo order", rx_count, 1);

    // Single-entry mode
    set_mode(0, 0);
    wr_valid = 1; wr_data = 16'h0044; tx_done = 1; cyc();
    chk("R4 single capacity", tx_count, 1);
    chk("R5 single done clears", tx_empty, 0);
    wr_valid = 1; wr_data = 16'h0055; cyc();
    chk("R8 single overflow", tx_overflow, 1);

    // Randomized runs in each mode
    for (int m = 0; m < 3; m++) begin
      set_mode(m != 0, m == 2);
      for (int n = 0; n < 1500; n++) begin
        spi_en     = ($urandom % 64) != 0;
        if ($urandom % 16 == 0) tx_dma_en = ~tx_dma_en;
        if ($urandom % 16 == 0) rx_dma_en = ~rx_dma_en;
        wr_valid   = $urandom % 2;
        wr_data    = 16'($urandom);
        tx_done    = ($urandom % 4) == 0;
        shift_tick = ($urandom % 3) == 0;
        rd_strobe  = ($urandom % 3) == 0;
        rx_done    = ($urandom % 4) == 0;
        cyc();
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule